// File: doc/BRIEF.md
# Bank-Pair Precharge and Refresh Tracker

This block follows the state of a four-bank memory array as the array itself would. Each clock it takes one decoded command from a small command bus. The commands are activate, read, write, single-bank precharge, precharge of every bank, paired precharge, and a background-refresh command whose entry or exit form is chosen by an address bit. It keeps one of four states per bank: IDLE, ACTIVE, PRECHARGING or REFRESH. Cycle counters time the precharge interval and the refresh interval, which is a multiple of a per-cycle refresh time.

Banks 0 and 1 form one pair and banks 2 and 3 form the other. A paired precharge or a refresh acts on a whole pair. While one pair is refreshing in the background, the other pair can still be activated, read and written. Any command that breaks a rule is ignored and raises a one-cycle error pulse. A per-bank flag shows which banks may be accessed.

Top module: `bank_pair_tracker`

## Requirements
- R1: While reset is high, and after reset until the first command takes effect, every bank reads IDLE (code 0), `err` is low and `access_ok` is 0. The state codes are IDLE=0, ACTIVE=1, PRECHARGING=2 and REFRESH=3. Bank b sits in `bank_state[2b+1:2b]`.
- R2: Activate (op 1) on an IDLE bank makes that bank ACTIVE after the next edge and sets its `access_ok` bit. Activate on a bank in any other state is flagged and changes nothing.
- R3: Single precharge (op 4) on an ACTIVE bank, or precharge-all (op 5) on every ACTIVE bank, makes the bank PRECHARGING for exactly TRP cycles and then IDLE. Precharge of an IDLE bank does nothing and is not flagged.
- R4: Paired precharge (op 6) acts on banks 0 and 1 when `cmd_bank[1]` is 0, and on banks 2 and 3 when it is 1. Each ACTIVE bank of that pair is precharged as in R3.
- R5: Background refresh with `cmd_addr[10]`=0 (op 7) takes a count N from `cmd_addr[4:0]`. It puts both banks of the pair chosen by `cmd_bank[1]` in REFRESH for N*TREFC cycles, after which both return to IDLE.
- R6: A refresh entry is flagged and ignored when its count is 0 or when either bank of the target pair is not IDLE.
- R7: While one pair refreshes, a refresh entry aimed at the other pair is flagged and ignored. Commands to the other pair's banks keep working.
- R8: Refresh exit (op 7 with `cmd_addr[10]`=1) during the target pair's refresh returns both banks to IDLE TREFC cycles after the command. An exit aimed at a pair that is not refreshing is flagged.
- R9: A read (op 2) or write (op 3) aimed at a bank that is not ACTIVE is flagged.
- R10: Paired precharge and both refresh forms are accepted only when `cmd_sa` is high. When it is low they are flagged and change nothing.
- R11: Precharge-all while any bank refreshes, and paired precharge of a refreshing pair, are flagged and change nothing.
- R12: `err` is high for exactly the one cycle after a flagged command and low after any accepted command or NOP (op 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command code (0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge all, 6 paired precharge, 7 background refresh) |
| cmd_bank | input | 2 | Target bank; bit 1 picks the pair |
| cmd_addr | input | 11 | Bit 10 picks refresh exit; bits 4:0 give the refresh count |
| cmd_sa | input | 1 | Qualifier required by paired precharge and refresh commands |
| bank_state | output | 8 | Two-bit state per bank |
| access_ok | output | 4 | Bank may be read or written (ACTIVE) |
| err | output | 1 | One-cycle pulse after an illegal command |

## Verification
Every result of this block is registered. A command driven before a clock edge shows its state change and its error pulse after that same edge, and the bench reads both at the following falling edge. Interval checks count edges from the command edge: PRECHARGING is seen for TRP samples, REFRESH for N*TREFC samples, and the exit tail for TREFC samples, and the vector table places NOP rows so that the last busy sample and the first IDLE sample are both compared.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    localparam int NBANK = 4;
    localparam int NPAIR = 2;
    localparam int RCW   = 5;

    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_ACTIVE = 2'd1,
        BS_PRECH  = 2'd2,
        BS_REFR   = 2'd3
    } bank_state_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4,
        OP_PALL  = 3'd5,
        OP_MPRE  = 3'd6,
        OP_BGREF = 3'd7
    } cmd_op_t;

    typedef struct packed {
        logic [NBANK-1:0] act;
        logic [NBANK-1:0] pre;
        logic [NPAIR-1:0] ref_start;
        logic [NPAIR-1:0] ref_exit;
        logic [RCW-1:0]   count;
        logic             err;
    } bank_req_t;

    function automatic int pair_of(input int bank);
        return bank / 2;
    endfunction
endpackage

// File: rtl/bpt_decode.sv
module bpt_decode
    import bpt_pkg::*;
(
    input  cmd_op_t                 op,
    input  logic [1:0]              bank,
    input  logic [10:0]             addr,
    input  logic                    sa,
    input  bank_state_t [NBANK-1:0] st,
    input  logic [NPAIR-1:0]        busy,
    output bank_req_t               req
);
    logic tgt_pair;
    logic any_refr;
    logic pair_refr;
    logic pair_idle;

    assign tgt_pair = bank[1];

    always_comb begin
        any_refr  = 1'b0;
        pair_refr = 1'b0;
        pair_idle = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            if (st[b] == BS_REFR) any_refr = 1'b1;
            if (pair_of(b) == int'(tgt_pair)) begin
                if (st[b] == BS_REFR) pair_refr = 1'b1;
                if (st[b] != BS_IDLE) pair_idle = 1'b0;
            end
        end
    end

    always_comb begin
        req = '0;
        unique case (op)
            OP_NOP: ;
            OP_ACT: begin
                if (st[bank] == BS_IDLE) req.act[bank] = 1'b1;
                else                     req.err = 1'b1;
            end
            OP_READ, OP_WRITE: begin
                if (st[bank] != BS_ACTIVE) req.err = 1'b1;
            end
            OP_PRE: begin
                if (st[bank] == BS_REFR)        req.err = 1'b1;
                else if (st[bank] == BS_ACTIVE) req.pre[bank] = 1'b1;
            end
            OP_PALL: begin
                if (any_refr) req.err = 1'b1;
                else
                    for (int b = 0; b < NBANK; b++)
                        req.pre[b] = (st[b] == BS_ACTIVE);
            end
            OP_MPRE: begin
                if (!sa || pair_refr) req.err = 1'b1;
                else
                    for (int b = 0; b < NBANK; b++)
                        req.pre[b] = (pair_of(b) == int'(tgt_pair)) && (st[b] == BS_ACTIVE);
            end
            OP_BGREF: begin
                if (!sa) req.err = 1'b1;
                else if (addr[10]) begin
                    if (busy[tgt_pair]) req.ref_exit[tgt_pair] = 1'b1;
                    else                req.err = 1'b1;
                end else if (addr[RCW-1:0] == '0 || busy[~tgt_pair] || !pair_idle) begin
                    req.err = 1'b1;
                end else begin
                    req.ref_start[tgt_pair] = 1'b1;
                    req.count               = addr[RCW-1:0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bpt_refresh.sv
module bpt_refresh
    import bpt_pkg::*;
#(
    parameter int TREFC = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           stop,
    input  logic [RCW-1:0] count,
    output logic           busy,
    output logic           done
);
    localparam int MAXCYC = ((1 << RCW) - 1) * TREFC;
    localparam int CW     = $clog2(MAXCYC + 1);

    logic [CW-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(count) * CW'(TREFC) - CW'(1);
        end else if (stop) begin
            remain <= CW'(TREFC - 1);
        end else if (done) begin
            busy   <= 1'b0;
        end else if (busy) begin
            remain <= remain - CW'(1);
        end
    end

    assert_done_ends_R5: assert property (@(posedge clk) disable iff (rst)
        done && !start && !stop |=> !busy);
    assert_stop_needs_busy_R8: assert property (@(posedge clk) disable iff (rst)
        stop |-> busy);
endmodule

// File: rtl/bpt_bank.sv
module bpt_bank
    import bpt_pkg::*;
#(
    parameter int TRP = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        act,
    input  logic        pre,
    input  logic        ref_start,
    input  logic        ref_done,
    output bank_state_t state
);
    localparam int PW = (TRP > 1) ? $clog2(TRP) : 1;

    logic [PW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BS_IDLE;
            wait_cnt <= '0;
        end else if (ref_start) begin
            state <= BS_REFR;
        end else if (ref_done && state == BS_REFR) begin
            state <= BS_IDLE;
        end else if (act) begin
            state <= BS_ACTIVE;
        end else if (pre) begin
            state    <= BS_PRECH;
            wait_cnt <= PW'(TRP - 1);
        end else if (state == BS_PRECH) begin
            if (wait_cnt == '0) state <= BS_IDLE;
            else                wait_cnt <= wait_cnt - PW'(1);
        end
    end

    assert_refr_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        ref_start |-> state == BS_IDLE);
    assert_prech_no_reopen_R3: assert property (@(posedge clk) disable iff (rst)
        state == BS_PRECH |=> state == BS_PRECH || state == BS_IDLE);
endmodule

// File: rtl/bank_pair_tracker.sv
module bank_pair_tracker
    import bpt_pkg::*;
#(
    parameter int TRP   = 2,
    parameter int TREFC = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cmd_op,
    input  logic [1:0]  cmd_bank,
    input  logic [10:0] cmd_addr,
    input  logic        cmd_sa,
    output logic [7:0]  bank_state,
    output logic [3:0]  access_ok,
    output logic        err
);
    bank_state_t [NBANK-1:0] st;
    logic [NPAIR-1:0]        busy;
    logic [NPAIR-1:0]        done;
    bank_req_t               req;

    bpt_decode u_dec (
        .op   (cmd_op_t'(cmd_op)),
        .bank (cmd_bank),
        .addr (cmd_addr),
        .sa   (cmd_sa),
        .st   (st),
        .busy (busy),
        .req  (req)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        bpt_refresh #(.TREFC(TREFC)) u_ref (
            .clk   (clk),
            .rst   (rst),
            .start (req.ref_start[p]),
            .stop  (req.ref_exit[p]),
            .count (req.count),
            .busy  (busy[p]),
            .done  (done[p])
        );

        assert_pair_lock_R5: assert property (@(posedge clk) disable iff (rst)
            (st[2*p] == BS_REFR) == busy[p] && (st[2*p+1] == BS_REFR) == busy[p]);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bpt_bank #(.TRP(TRP)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .act       (req.act[b]),
            .pre       (req.pre[b]),
            .ref_start (req.ref_start[b/2]),
            .ref_done  (done[b/2]),
            .state     (st[b])
        );
        assign bank_state[2*b +: 2] = st[b];
        assign access_ok[b]         = (st[b] == BS_ACTIVE);
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= req.err;
    end

    assert_one_pair_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy[0] && busy[1]));
    assert_quiet_nop_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 3'd0 |=> !err);
    assert_sa_gate_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 3'd7 && !cmd_sa |=> err);
endmodule

// File: tb/bank_pair_tracker_tb_top.sv
module bank_pair_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_bank = '0;
    logic [10:0] cmd_addr = '0;
    logic        cmd_sa = 1'b0;
    logic [7:0]  bank_state;
    logic [3:0]  access_ok;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    bank_pair_tracker #(.TRP(2), .TREFC(3)) dut_i (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_sa(cmd_sa), .bank_state(bank_state),
        .access_ok(access_ok), .err(err)
    );

    // fields: op[25:23] bank[22:21] addr[20:10] sa[9] err[8] states[7:0]
    localparam int NV = 37;
    localparam logic [25:0] VEC [NV] = '{
        {3'd1, 2'd0, 11'h000, 1'b0, 1'b0, 8'h01},  // 0  R2
        {3'd1, 2'd1, 11'h000, 1'b0, 1'b0, 8'h05},  // 1  R2
        {3'd2, 2'd0, 11'h000, 1'b0, 1'b0, 8'h05},  // 2  R9 legal read
        {3'd1, 2'd0, 11'h000, 1'b0, 1'b1, 8'h05},  // 3  R2 reactivate
        {3'd4, 2'd0, 11'h000, 1'b0, 1'b0, 8'h06},  // 4  R3
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h06},  // 5  R3
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h04},  // 6  R3
        {3'd2, 2'd0, 11'h000, 1'b0, 1'b1, 8'h04},  // 7  R9
        {3'd6, 2'd0, 11'h000, 1'b0, 1'b1, 8'h04},  // 8  R10
        {3'd6, 2'd0, 11'h000, 1'b1, 1'b0, 8'h08},  // 9  R4
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h08},  // 10 R4
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00},  // 11 R4
        {3'd1, 2'd2, 11'h000, 1'b0, 1'b0, 8'h10},  // 12 R2
        {3'd7, 2'd0, 11'h002, 1'b1, 1'b0, 8'h1F},  // 13 R5
        {3'd2, 2'd2, 11'h000, 1'b0, 1'b0, 8'h1F},  // 14 R7
        {3'd7, 2'd2, 11'h001, 1'b1, 1'b1, 8'h1F},  // 15 R7
        {3'd2, 2'd0, 11'h000, 1'b0, 1'b1, 8'h1F},  // 16 R9
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h1F},  // 17 R5
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h1F},  // 18 R5
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h10},  // 19 R5
        {3'd7, 2'd0, 11'h400, 1'b1, 1'b1, 8'h10},  // 20 R8
        {3'd7, 2'd0, 11'h000, 1'b1, 1'b1, 8'h10},  // 21 R6
        {3'd7, 2'd2, 11'h001, 1'b1, 1'b1, 8'h10},  // 22 R6
        {3'd7, 2'd0, 11'h01F, 1'b1, 1'b0, 8'h1F},  // 23 R5
        {3'd7, 2'd1, 11'h400, 1'b1, 1'b0, 8'h1F},  // 24 R8
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h1F},  // 25 R8
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h1F},  // 26 R8
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h10},  // 27 R8
        {3'd5, 2'd0, 11'h000, 1'b0, 1'b0, 8'h20},  // 28 R3
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h20},  // 29 R3
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00},  // 30 R3
        {3'd3, 2'd3, 11'h000, 1'b0, 1'b1, 8'h00},  // 31 R9
        {3'd7, 2'd0, 11'h400, 1'b0, 1'b1, 8'h00},  // 32 R10
        {3'd7, 2'd3, 11'h001, 1'b1, 1'b0, 8'hF0},  // 33 R5
        {3'd5, 2'd0, 11'h000, 1'b0, 1'b1, 8'hF0},  // 34 R11
        {3'd1, 2'd0, 11'h000, 1'b0, 1'b0, 8'hF1},  // 35 R7
        {3'd0, 2'd0, 11'h000, 1'b0, 1'b0, 8'h01}   // 36 R5
    };
    localparam int REQ [NV] = '{2,2,9,2,3,3,3,9,10,4,4,4,2,5,7,7,9,5,5,5,
                                8,6,6,5,8,8,8,8,3,3,3,9,10,5,11,7,5};

    function automatic logic [3:0] ok_of(input logic [7:0] s);
        for (int b = 0; b < 4; b++) ok_of[b] = (s[2*b +: 2] == 2'd1);
    endfunction

    task automatic check(input int req, input logic e_err, input logic [7:0] e_st);
        checks++;
        if (err !== e_err || bank_state !== e_st || access_ok !== ok_of(e_st)) begin
            errors++;
            $display("FAIL R%0d: err=%0b st=%h ok=%h, expected err=%0b st=%h ok=%h",
                     req, err, bank_state, access_ok, e_err, e_st, ok_of(e_st));
        end
    endtask

    task automatic drive(input logic [25:0] v);
        cmd_op   = v[25:23];
        cmd_bank = v[22:21];
        cmd_addr = v[20:10];
        cmd_sa   = v[9];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b0, 8'h00);          // R1 during reset
        rst = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 8'h00);          // R1 after reset
        drive(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(REQ[i], VEC[i][8], VEC[i][7:0]);
            if (i + 1 < NV) drive(VEC[i+1]);
            else            drive('0);
        end
        // R1: reset mid-run clears an open bank
        drive({3'd1, 2'd3, 11'h000, 1'b0, 1'b0, 8'h00});
        @(negedge clk);
        check(2, 1'b0, 8'h41);
        drive('0);
        rst = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 8'h00);
        rst = 1'b0;
        // R12: error pulse lasts one cycle
        drive({3'd2, 2'd1, 11'h000, 1'b0, 1'b0, 8'h00});
        @(negedge clk);
        check(12, 1'b1, 8'h00);
        drive('0);
        @(negedge clk);
        check(12, 1'b0, 8'h00);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule